// File: doc/BRIEF.md
# Lockable Thermal Control Register

This block holds the settings a memory thermal throttling monitor works from: one 64-bit control word, reached as a lower and an upper 32-bit word on a plain register bus. Software writes whole 32-bit words and can read them back at any time. The block decodes the upper word into a test-mode flag, an 8-bit sampling window and a 13-bit activity threshold. It hands these to the monitor together with the whole lower word and its start bit.

A two-bit lock field at the top of the upper word makes the settings write-once. Once software writes a nonzero value there, the lock holds until the next reset and it also guards itself. One lock setting freezes everything except the start bit in bit 0 of the lower word, so the monitor can still be started and stopped. The other settings freeze the whole register.

Top module: `thermctl_regfile`

## Requirements
- R1: After reset both words read as zero, the lock field is 00 and every decoded output is zero.
- R2: With the lock field at 00, a write to the lower word stores all 32 bits of the write data.
- R3: Bits 28:21 of the upper word always read as zero; writing ones there has no effect.
- R4: With the lock field at 01, a lower-word write changes only bit 0 (the start bit), and upper-word writes change nothing, the lock field included.
- R5: With the lock field at 10, every write to either word is ignored, the start bit included.
- R6: The lock value 11 behaves like 10 (full freeze) and reads back as 11.
- R7: With the lock field at 00, a single upper-word write stores the lock field (bits 31:30), test mode (bit 29), window (bits 20:13) and threshold (bits 12:0) together. A newly written lock value governs only later writes.
- R8: A nonzero lock field holds its value until reset, and reset returns it to 00.
- R9: start_o follows lower bit 0, lo_cfg_o the whole lower word, test_mode_o upper bit 29, window_o upper bits 20:13, threshold_o upper bits 12:0 and lock_o upper bits 31:30.
- R10: reg_rdata shows the word selected by reg_addr in the same cycle (LO_ADDR lower, HI_ADDR upper). Any other address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address |
| reg_wr | input | 1 | Full-word write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| lo_cfg_o | output | 32 | Lower word contents |
| start_o | output | 1 | Start bit (lower bit 0) |
| test_mode_o | output | 1 | Shortened-timing test mode |
| window_o | output | 8 | Sampling window code |
| threshold_o | output | 13 | Activity threshold code |
| lock_o | output | 2 | Current lock field |

## Verification
The bench builds the block with ADDR_W = 3, LO_ADDR = 2 and HI_ADDR = 5. The two words therefore sit at non-adjacent addresses, and the address space holds several unmapped words. Writes to those words can then be checked for having no effect. The same build exercises the decoder on addresses that differ from the mapped ones in more than one bit. Reset is pulsed during the run, so each lock setting is tried from a clean register and the lock is seen to clear.

// File: rtl/thermctl_pkg.sv
package thermctl_pkg;

  localparam int WORD_W   = 32;
  localparam int LOCK_HI  = 31;
  localparam int LOCK_LO  = 30;
  localparam int TME_BIT  = 29;
  localparam int RSV_HI   = 28;
  localparam int RSV_LO   = 21;
  localparam int WIN_HI   = 20;
  localparam int WIN_LO   = 13;
  localparam int THR_HI   = 12;
  localparam int THR_LO   = 0;
  localparam int WIN_W    = WIN_HI - WIN_LO + 1;
  localparam int THR_W    = THR_HI - THR_LO + 1;
  localparam int START_BIT = 0;

  typedef enum logic [1:0] {
    MODE_OPEN       = 2'd0,
    MODE_START_ONLY = 2'd1,
    MODE_FROZEN     = 2'd2
  } lock_mode_e;

  // Implemented bits of the upper word (reserved span cleared).
  function automatic logic [WORD_W-1:0] hi_impl_mask();
    logic [WORD_W-1:0] m;
    m = '1;
    for (int b = RSV_LO; b <= RSV_HI; b++) m[b] = 1'b0;
    return m;
  endfunction

  function automatic lock_mode_e mode_of(input logic [1:0] lk);
    lock_mode_e md;
    case (lk)
      2'b00:   md = MODE_OPEN;
      2'b01:   md = MODE_START_ONLY;
      default: md = MODE_FROZEN;   // 10 and reserved 11
    endcase
    return md;
  endfunction

  function automatic logic [WORD_W-1:0] lo_mask_for(input lock_mode_e md);
    logic [WORD_W-1:0] m;
    m = '0;
    case (md)
      MODE_OPEN:       m = '1;
      MODE_START_ONLY: m[START_BIT] = 1'b1;
      default:         m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] hi_mask_for(input lock_mode_e md);
    return (md == MODE_OPEN) ? hi_impl_mask() : '0;
  endfunction

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old_v,
                                              input logic [WORD_W-1:0] new_v,
                                              input logic [WORD_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/thermctl_addr_dec.sv
module thermctl_addr_dec #(
  parameter int ADDR_W  = 4,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              sel_lo,
  output logic              sel_hi,
  output logic              wr_lo,
  output logic              wr_hi
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

  always_comb begin
    sel_lo = (addr == LO_A);
    sel_hi = (addr == HI_A);
    wr_lo  = wr && sel_lo;
    wr_hi  = wr && sel_hi;
  end
endmodule

// File: rtl/thermctl_lock_ctl.sv
module thermctl_lock_ctl
  import thermctl_pkg::*;
(
  input  logic [1:0]        lock_field,
  output lock_mode_e        mode,
  output logic [WORD_W-1:0] lo_wmask,
  output logic [WORD_W-1:0] hi_wmask
);
  always_comb begin
    mode     = mode_of(lock_field);
    lo_wmask = lo_mask_for(mode);
    hi_wmask = hi_mask_for(mode);
  end
endmodule

// File: rtl/thermctl_half_reg.sv
module thermctl_half_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (we)  q <= (q & ~wmask) | (wdata & wmask);
  end
endmodule

// File: rtl/thermctl_regfile.sv
module thermctl_regfile
  import thermctl_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [31:0]       lo_cfg_o,
  output logic              start_o,
  output logic              test_mode_o,
  output logic [7:0]        window_o,
  output logic [12:0]       threshold_o,
  output logic [1:0]        lock_o
);
  // Named internal events for the checker
  logic              sel_lo, sel_hi;
  logic              wr_lo_hit, wr_hi_hit;
  lock_mode_e        lock_mode;
  logic [WORD_W-1:0] lo_wmask, hi_wmask;
  logic [WORD_W-1:0] lo_q, hi_q;

  thermctl_addr_dec #(
    .ADDR_W (ADDR_W),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) u_dec (
    .addr  (reg_addr),
    .wr    (reg_wr),
    .sel_lo(sel_lo),
    .sel_hi(sel_hi),
    .wr_lo (wr_lo_hit),
    .wr_hi (wr_hi_hit)
  );

  thermctl_lock_ctl u_lock (
    .lock_field(hi_q[LOCK_HI:LOCK_LO]),
    .mode      (lock_mode),
    .lo_wmask  (lo_wmask),
    .hi_wmask  (hi_wmask)
  );

  thermctl_half_reg #(.W(WORD_W)) u_lo (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_lo_hit),
    .wdata(reg_wdata),
    .wmask(lo_wmask),
    .q    (lo_q)
  );

  thermctl_half_reg #(.W(WORD_W)) u_hi (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_hi_hit),
    .wdata(reg_wdata),
    .wmask(hi_wmask),
    .q    (hi_q)
  );

  always_comb begin
    if (sel_lo)      reg_rdata = lo_q;
    else if (sel_hi) reg_rdata = hi_q & hi_impl_mask();
    else             reg_rdata = '0;
  end

  assign lo_cfg_o    = lo_q;
  assign start_o     = lo_q[START_BIT];
  assign test_mode_o = hi_q[TME_BIT];
  assign window_o    = hi_q[WIN_HI:WIN_LO];
  assign threshold_o = hi_q[THR_HI:THR_LO];
  assign lock_o      = hi_q[LOCK_HI:LOCK_LO];

endmodule

// File: rtl/thermctl_chk.sv
module thermctl_chk
  import thermctl_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              wr_lo_hit,
  input logic              wr_hi_hit,
  input lock_mode_e        lock_mode,
  input logic [31:0]       lo_q,
  input logic [31:0]       hi_q
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
  localparam logic [31:0] IMPL = 32'hE01F_FFFF;

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lo_q == '0 && hi_q == '0));

  // R2
  lo_open_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_hit && lock_mode == MODE_OPEN) |=> (lo_q == $past(reg_wdata)));

  // R7
  hi_open_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_hit && lock_mode == MODE_OPEN) |=> (hi_q == ($past(reg_wdata) & IMPL)));

  // R3
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == HI_A) |-> (reg_rdata[28:21] == 8'h00));

  // R4
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mode == MODE_START_ONLY) |=> ($stable(hi_q) && $stable(lo_q[31:1])));

  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mode == MODE_FROZEN) |=> ($stable(hi_q) && $stable(lo_q)));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q[31:30] != 2'b00) |=> $stable(hi_q[31:30]));

  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != LO_A && reg_addr != HI_A) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

bind thermctl_regfile thermctl_chk #(
  .ADDR_W (ADDR_W),
  .LO_ADDR(LO_ADDR),
  .HI_ADDR(HI_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .wr_lo_hit(wr_lo_hit),
  .wr_hi_hit(wr_hi_hit),
  .lock_mode(lock_mode),
  .lo_q     (lo_q),
  .hi_q     (hi_q)
);

// File: tb/test_thermctl_regfile.sv
module test_thermctl_regfile;
  localparam int AW = 3;
  localparam int LO = 2;
  localparam int HI = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata, lo_cfg_o;
  logic          start_o, test_mode_o;
  logic [7:0]    window_o;
  logic [12:0]   threshold_o;
  logic [1:0]    lock_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state
  bit [31:0] m_lo, m_hi;

  always #10 clk = ~clk;   // 50 MHz

  thermctl_regfile #(.ADDR_W(AW), .LO_ADDR(LO), .HI_ADDR(HI)) i_thermctl_regfile (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lo_cfg_o(lo_cfg_o),
    .start_o(start_o), .test_mode_o(test_mode_o), .window_o(window_o),
    .threshold_o(threshold_o), .lock_o(lock_o)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural model: lock read from model upper bits
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo <= 0;
      m_hi <= 0;
    end else if (reg_wr) begin
      if (int'(reg_addr) == LO) begin
        if (m_hi[31:30] == 2'b00)      m_lo <= reg_wdata;
        else if (m_hi[31:30] == 2'b01) m_lo <= {m_lo[31:1], reg_wdata[0]};
      end else if (int'(reg_addr) == HI && m_hi[31:30] == 2'b00) begin
        m_hi <= {reg_wdata[31:29], 8'h00, reg_wdata[20:0]};
      end
    end
  end

  // Every-clock comparison, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R9 lo_cfg", lo_cfg_o, m_lo);
      cmp("R9 start", 32'(start_o), 32'(m_lo[0]));
      cmp("R9 tme", 32'(test_mode_o), 32'(m_hi[29]));
      cmp("R9 window", 32'(window_o), 32'(m_hi[20:13]));
      cmp("R9 thr", 32'(threshold_o), 32'(m_hi[12:0]));
      cmp("R8 lock", 32'(lock_o), 32'(m_hi[31:30]));
      cmp("R10 rdata", reg_rdata,
          (int'(reg_addr) == LO) ? m_lo : (int'(reg_addr) == HI) ? m_hi : 32'h0);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #5;
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #5;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(posedge clk); #5;
    reg_addr = AW'(a); reg_wr = 1'b0;
    #10;
    cmp(tag, reg_rdata, exp);
  endtask

  task automatic do_reset();
    @(posedge clk); #5;
    rst_n = 1'b0;
    #40;
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #45 rst_n = 1'b1;
    // R1 reset state
    rd(LO, 32'h0, "R1 lower after reset");
    rd(HI, 32'h0, "R1 upper after reset");
    cmp("R1 lock after reset", 32'(lock_o), 32'h0);

    // R2 open lower write
    wr(LO, 32'hA5A5_5A5B);
    rd(LO, 32'hA5A5_5A5B, "R2 lower write");

    // R3 reserved bits dropped, R9 decode
    wr(HI, 32'h3FFF_FFFF);
    rd(HI, 32'h201F_FFFF, "R3 reserved read zero");
    cmp("R9 window", 32'(window_o), 32'hFF);
    cmp("R9 threshold", 32'(threshold_o), 32'h1FFF);
    cmp("R9 test mode", 32'(test_mode_o), 32'h1);

    // R10 unmapped write and read
    wr(7, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    rd(LO, 32'hA5A5_5A5B, "R10 lower after unmapped writes");
    rd(HI, 32'h201F_FFFF, "R10 upper after unmapped writes");
    rd(7, 32'h0, "R10 unmapped read");

    // R7 lock and fields land from one write
    wr(HI, 32'h4000_2003);
    rd(HI, 32'h4000_2003, "R7 same-write fields");
    cmp("R7 window", 32'(window_o), 32'h01);
    cmp("R7 threshold", 32'(threshold_o), 32'h0003);

    // R4 start-only lock
    wr(LO, 32'h0000_0000);
    rd(LO, 32'hA5A5_5A5A, "R4 only start bit cleared");
    wr(LO, 32'hFFFF_FFFF);
    rd(LO, 32'hA5A5_5A5B, "R4 only start bit set");
    wr(HI, 32'h0000_0000);
    rd(HI, 32'h4000_2003, "R4 upper frozen");
    cmp("R8 lock holds", 32'(lock_o), 32'h1);

    // R8 reset clears lock
    do_reset();
    rd(HI, 32'h0, "R8 upper cleared by reset");
    rd(LO, 32'h0, "R8 lower cleared by reset");

    // R5 full lock
    wr(HI, 32'h8000_1234);
    rd(HI, 32'h8000_1234, "R5 lock 10 stored");
    wr(LO, 32'h0000_0001);
    rd(LO, 32'h0, "R5 start bit frozen");
    wr(HI, 32'h0000_0000);
    rd(HI, 32'h8000_1234, "R5 upper frozen");

    // R6 reserved lock value
    do_reset();
    wr(HI, 32'hC000_0000);
    rd(HI, 32'hC000_0000, "R6 lock 11 reads back");
    wr(LO, 32'h0000_0001);
    rd(LO, 32'h0, "R6 start bit frozen");
    wr(HI, 32'h0000_00FF);
    rd(HI, 32'hC000_0000, "R6 upper frozen");

    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule